// File: doc/BRIEF.md
# Ring Privilege Access Checker

This block keeps the current ring number of a processor core in a two-bit register and rules on each segment access or control transfer that the core asks about. Every request names an access kind, the selector involved, the privilege field of the descriptor it targets and, for transfers through a gate, the privilege field of the code segment behind that gate. The checker answers one cycle later with either a grant or a general-protection fault. A granted transfer also moves the ring to its new value on the same edge. Descriptors come in already decoded, so the block contains no table lookup.

Two separate rules drive most of the decisions. A data access is compared against both the current ring and the requested level in the selector's low two bits. A transfer through a gate is compared against the gate's own level, but the ring it lands in comes from the target code segment. An instruction reserved for the most privileged ring raises a separate violation flag beside the fault when it is issued from any other ring. Lower ring numbers carry more privilege.

Top module: `priv_chk`

## Requirements
- R1: While reset is high and on the first cycle after it, the current level is 0 and neither grant, fault nor violation is asserted.
- R2: A data access (kind code 0) is granted only when the current level is at most the descriptor level and the selector's requested level (selector bits 1:0) is at most the descriptor level. The current level does not change.
- R3: A same-ring call or jump (kind code 1) is granted only when the current level equals the descriptor level. The current level does not change.
- R4: A gate call (kind code 2) or an interrupt entry (kind code 3) is granted only when the current level is at most the gate's descriptor level. On a grant the current level becomes the target code segment level.
- R5: A return (kind code 4) is granted only when the selector's requested level (bits 1:0) is at least the current level. On a grant the current level becomes that requested level.
- R6: A privileged instruction (kind code 5) is granted only at level 0. From any other level it faults and asserts the privilege-violation flag together with the fault.
- R7: Kind codes 6 and 7 always fault. A faulting request never changes the current level.
- R8: Each accepted request yields exactly one response cycle, one cycle after acceptance, with grant and fault mutually exclusive. No response appears in a cycle that follows no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (high outside reset) |
| req_kind | input | 3 | Access kind code |
| req_sel | input | 16 | Selector; bits 1:0 are the requested level |
| req_desc_lvl | input | 2 | Privilege field of the target descriptor or gate |
| req_tgt_lvl | input | 2 | Privilege field of the code segment behind a gate |
| rsp_grant | output | 1 | One-cycle grant for the last accepted request |
| rsp_fault | output | 1 | One-cycle general-protection fault |
| rsp_priv_viol | output | 1 | Privileged instruction issued outside level 0 |
| cur_lvl | output | 2 | Current privilege level |

## Verification
Every one of the eight kind codes is applied from all four starting levels, crossed with every requested level, descriptor level and target level. This covers 2048 patterns. Before each pattern the bench first moves the block to the chosen level through a gate. The full cross separates the data rule from the gate rule: a gate grant ignores the requested level, while a data grant depends on it. It also separates landing on the gate level from landing on the target level, and it shows whether a return can raise privilege. After each response the bench reads back the level, which shows that faults leave it alone. An idle cycle after each response confirms that every request gives exactly one response.

// File: rtl/priv_chk_pkg.sv
package priv_chk_pkg;

    localparam int LVL_W  = 2;
    localparam int SEL_W  = 16;
    localparam int KIND_W = 3;

    typedef logic [LVL_W-1:0] ring_t;

    typedef enum logic [KIND_W-1:0] {
        K_DATA  = 3'd0,
        K_NEAR  = 3'd1,
        K_GATE  = 3'd2,
        K_INTR  = 3'd3,
        K_RET   = 3'd4,
        K_PRIV  = 3'd5,
        K_RSV6  = 3'd6,
        K_RSV7  = 3'd7
    } acc_kind_e;

    typedef struct packed {
        logic [SEL_W-4:0] index;
        logic             tbl;
        ring_t            rpl;
    } selector_t;

    typedef struct packed {
        acc_kind_e kind;
        selector_t sel;
        ring_t     desc_lvl;
        ring_t     tgt_lvl;
    } acc_req_t;

    typedef struct packed {
        logic  ok;
        logic  priv_viol;
        ring_t next_lvl;
    } verdict_t;

    function automatic logic at_least_as_priv(ring_t a, ring_t b);
        return a <= b;
    endfunction

endpackage

// File: rtl/priv_rule_eval.sv
module priv_rule_eval
    import priv_chk_pkg::*;
(
    input  acc_req_t req,
    input  ring_t    cpl,
    output verdict_t verdict
);
    always_comb begin
        verdict.ok        = 1'b0;
        verdict.priv_viol = 1'b0;
        verdict.next_lvl  = cpl;
        unique case (req.kind)
            K_DATA: begin
                verdict.ok = at_least_as_priv(cpl, req.desc_lvl) &&
                             at_least_as_priv(req.sel.rpl, req.desc_lvl);
            end
            K_NEAR: begin
                verdict.ok = (cpl == req.desc_lvl);
            end
            K_GATE, K_INTR: begin
                verdict.ok = at_least_as_priv(cpl, req.desc_lvl);
                if (verdict.ok) verdict.next_lvl = req.tgt_lvl;
            end
            K_RET: begin
                verdict.ok = at_least_as_priv(cpl, req.sel.rpl);
                if (verdict.ok) verdict.next_lvl = req.sel.rpl;
            end
            K_PRIV: begin
                verdict.ok        = (cpl == '0);
                verdict.priv_viol = (cpl != '0);
            end
            default: begin
                verdict.ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/priv_lvl_reg.sv
module priv_lvl_reg
    import priv_chk_pkg::*;
#(
    parameter ring_t RESET_LVL = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  ring_t next_lvl,
    output ring_t lvl
);
    always_ff @(posedge clk) begin
        if (rst)       lvl <= RESET_LVL;
        else if (load) lvl <= next_lvl;
    end
endmodule

// File: rtl/priv_rsp_reg.sv
module priv_rsp_reg
    import priv_chk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  verdict_t verdict,
    output logic     grant,
    output logic     fault,
    output logic     viol
);
    always_ff @(posedge clk) begin
        if (rst || !accept) begin
            grant <= 1'b0;
            fault <= 1'b0;
            viol  <= 1'b0;
        end else begin
            grant <= verdict.ok;
            fault <= !verdict.ok;
            viol  <= verdict.priv_viol;
        end
    end
endmodule

// File: rtl/priv_chk.sv
module priv_chk
    import priv_chk_pkg::*;
#(
    parameter ring_t RESET_LVL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [LVL_W-1:0]  req_desc_lvl,
    input  logic [LVL_W-1:0]  req_tgt_lvl,
    output logic              rsp_grant,
    output logic              rsp_fault,
    output logic              rsp_priv_viol,
    output logic [LVL_W-1:0]  cur_lvl
);
    acc_req_t req;
    verdict_t verdict;
    ring_t    lvl_q;
    logic     accept;

    assign req_ready = !rst;
    assign accept    = req_valid && req_ready;

    assign req.kind     = acc_kind_e'(req_kind);
    assign req.sel      = selector_t'(req_sel);
    assign req.desc_lvl = req_desc_lvl;
    assign req.tgt_lvl  = req_tgt_lvl;

    priv_rule_eval u_eval (
        .req     (req),
        .cpl     (lvl_q),
        .verdict (verdict)
    );

    priv_lvl_reg #(.RESET_LVL(RESET_LVL)) u_lvl (
        .clk      (clk),
        .rst      (rst),
        .load     (accept && verdict.ok),
        .next_lvl (verdict.next_lvl),
        .lvl      (lvl_q)
    );

    priv_rsp_reg u_rsp (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .verdict (verdict),
        .grant   (rsp_grant),
        .fault   (rsp_fault),
        .viol    (rsp_priv_viol)
    );

    assign cur_lvl = lvl_q;
endmodule

// File: rtl/priv_chk_sva.sv
module priv_chk_sva (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] req_kind,
    input logic [1:0] req_desc_lvl,
    input logic       rsp_grant,
    input logic       rsp_fault,
    input logic       rsp_priv_viol,
    input logic [1:0] cur_lvl
);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rsp_grant && rsp_fault));

    a_r8_one_resp: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (rsp_grant || rsp_fault));

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !(rsp_grant || rsp_fault));

    a_r7_fault_holds: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (cur_lvl == $past(cur_lvl)));

    a_r6_viol_faults: assert property (@(posedge clk) disable iff (rst)
        rsp_priv_viol |-> rsp_fault);

    a_r6_ring0_priv: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_kind == 3'd5 && cur_lvl == 2'd0) |=> rsp_grant);

    a_r4_gate_denied: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_kind == 3'd2 && cur_lvl > req_desc_lvl) |=> rsp_fault);

    a_r7_reserved: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_kind[2:1] == 2'b11) |=> rsp_fault);
endmodule

bind priv_chk priv_chk_sva u_sva (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_kind      (req_kind),
    .req_desc_lvl  (req_desc_lvl),
    .rsp_grant     (rsp_grant),
    .rsp_fault     (rsp_fault),
    .rsp_priv_viol (rsp_priv_viol),
    .cur_lvl       (cur_lvl)
);

// File: tb/priv_chk_tb.sv
module priv_chk_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_sel = '0;
    logic [1:0]  req_desc_lvl = '0;
    logic [1:0]  req_tgt_lvl = '0;
    logic        rsp_grant, rsp_fault, rsp_priv_viol;
    logic [1:0]  cur_lvl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    priv_chk u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_sel(req_sel), .req_desc_lvl(req_desc_lvl),
        .req_tgt_lvl(req_tgt_lvl), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
        .rsp_priv_viol(rsp_priv_viol), .cur_lvl(cur_lvl)
    );

    function automatic string tag_of(int k);
        case (k)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic send(int k, int sel_lo, int dpl, int tgt);
        @(negedge clk);
        req_valid    = 1'b1;
        req_kind     = 3'(k);
        req_sel      = {13'h0a5, 1'b1, 2'(sel_lo)};
        req_desc_lvl = 2'(dpl);
        req_tgt_lvl  = 2'(tgt);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "level in reset", cur_lvl, 0);
        check("R1", "grant in reset", rsp_grant, 0);
        check("R1", "fault in reset", rsp_fault, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "level after reset", cur_lvl, 0);
        check("R1", "no response after reset", rsp_grant | rsp_fault | rsp_priv_viol, 0);

        for (int cpl = 0; cpl < 4; cpl++) begin
            for (int k = 0; k < 8; k++) begin
                for (int rpl = 0; rpl < 4; rpl++) begin
                    for (int dpl = 0; dpl < 4; dpl++) begin
                        for (int tgt = 0; tgt < 4; tgt++) begin
                            bit ok;
                            int nl;
                            bit pv;
                            // move to the starting level through an always-open gate
                            send(2, 0, 3, cpl);
                            check("R4", "setup gate grant", rsp_grant, 1);
                            check("R4", "setup level", cur_lvl, cpl);
                            nl = cpl;
                            pv = 1'b0;
                            case (k)
                                0: ok = (cpl <= dpl) && (rpl <= dpl);
                                1: ok = (cpl == dpl);
                                2, 3: begin ok = (cpl <= dpl); if (ok) nl = tgt; end
                                4: begin ok = (rpl >= cpl); if (ok) nl = rpl; end
                                5: begin ok = (cpl == 0); pv = (cpl != 0); end
                                default: ok = 1'b0;
                            endcase
                            send(k, rpl, dpl, tgt);
                            check(tag_of(k), "grant", rsp_grant, ok);
                            check(tag_of(k), "fault", rsp_fault, !ok);
                            check(ok ? tag_of(k) : "R7", "level after", cur_lvl, nl);
                            check("R6", "violation flag", rsp_priv_viol, pv);
                            @(negedge clk);
                            check("R8", "idle cycle silent", rsp_grant | rsp_fault, 0);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule